// File: doc/BRIEF.md
# Automatic Thermal Scan Controller

The block runs temperature sensing on its own. Software sets it up through a small register bus. Once enabled, it works through a set of sensor channels on an external converter, using a one-cycle start pulse and a done strobe for each conversion. It keeps the latest 12-bit code for every channel. The sensor codes fall as the die gets hotter, so a channel counts as over a limit when its code is equal to or lower than the compare value for that limit.

Each channel has two limits, an alarm limit and a shutdown limit. Each limit has its own consecutive-sample debounce. An alarm sets a pending flag, and the pending flag can raise the interrupt. A shutdown is latched for the channel. It can be routed to a polarity-selectable board pin, to a chip-reset request, or to both. After a scan in which any sample crossed a limit, the idle gap before the next scan uses the fast period instead of the normal one. The period counter counts prescaled clock ticks.

Top module: `tsc_thermal_scan`

## Requirements
- R1: Register offsets are 0x04 control, 0x08 interrupt enable, 0x0C pending, 0x20+4n data, 0x30+4n alarm compare, 0x40+4n shutdown compare, 0x60 alarm debounce, 0x64 shutdown debounce, 0x68 normal period and 0x6C fast period. After reset, both debounce registers read 4, the period registers read their parameter defaults, and every other register reads 0.
- R2: Control bit 0 enables scanning, and bit 4+n selects channel n. The selected channels are converted in ascending index order. Each conversion gets one single-cycle start pulse, with the channel index driven on the channel output.
- R3: A data register holds the last code returned for its channel. It reads 0 until that channel has been converted.
- R4: When the last sample of a scan did not cross a limit, the next scan's start pulse comes normal_period × PRESCALE cycles after the clock edge that samples the last done strobe.
- R5: When any sample of the previous scan was at or below its alarm or shutdown compare value, the fast period sets the gap instead. A following scan with no crossing returns the gap to the normal period.
- R6: Pending bit n (0..NCH-1) sets on the sample that completes alarm-debounce consecutive samples at or below channel n's alarm compare value. A sample above the compare value restarts the count. A debounce value of 0 behaves as 1.
- R7: irq_o is high exactly when some pending alarm bit n is set while interrupt-enable bit n is set. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R8: Pending bit 8 sets on every completed conversion and is cleared by writing 1 to it.
- R9: A selected channel whose code stays at or below its shutdown compare value for shutdown-debounce consecutive samples latches a shutdown that lasts until reset. A latched channel n drives the pin when interrupt-enable bit 4+n is set, and drives shut_rst_o when bit 8+n is set.
- R10: Control bit 8 sets the pin polarity. With bit 8 set, the pin is high while active. With bit 8 clear, the pin is low while active, so it idles high.
- R11: Clearing control bit 0 lets a conversion already in progress finish and store its code. No further start pulse follows, and the stored data and pending flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Register byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| adc_start_o | output | 1 | Conversion start pulse |
| adc_chan_o | output | CH_W | Channel being converted |
| adc_done_i | input | 1 | Conversion complete strobe |
| adc_code_i | input | CODE_W | Conversion result, valid with the done strobe |
| irq_o | output | 1 | Alarm interrupt |
| shut_gpio_o | output | 1 | Shutdown pin, polarity selectable |
| shut_rst_o | output | 1 | Shutdown reset request |

## Verification
The bench builds the block with PRESCALE = 2, a normal period of 6 ticks and a fast period of 2 ticks, and selects channels 0 and 2. With these values a normal gap is 12 cycles and a fast gap is 4 cycles, so many scans fit in a short run. That makes it practical to check the switch between fast and normal gaps, alarm runs that are broken by a cool sample, debounce counts of 2 and 3, and the latched shutdown after its channel has cooled again. Channel 1 is left unselected, which shows that an unscanned data register keeps reading 0.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam logic [7:0] OFF_CTRL  = 8'h04;
  localparam logic [7:0] OFF_IEN   = 8'h08;
  localparam logic [7:0] OFF_PEND  = 8'h0C;
  localparam logic [7:0] OFF_DATA  = 8'h20;
  localparam logic [7:0] OFF_ACMP  = 8'h30;
  localparam logic [7:0] OFF_SCMP  = 8'h40;
  localparam logic [7:0] OFF_ADB   = 8'h60;
  localparam logic [7:0] OFF_SDB   = 8'h64;
  localparam logic [7:0] OFF_PNORM = 8'h68;
  localparam logic [7:0] OFF_PFAST = 8'h6C;

  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned CH_FIELD  = 4;
  localparam int unsigned POL_BIT   = 8;
  localparam int unsigned GPIO_FLD  = 4;
  localparam int unsigned RST_FLD   = 8;
  localparam int unsigned EOC_BIT   = 8;

  typedef enum logic [1:0] {S_IDLE, S_START, S_WAIT, S_GAP} scan_state_e;
endpackage

// File: rtl/tsc_scan_seq.sv
module tsc_scan_seq
  import tsc_pkg::*;
#(
  parameter int unsigned NCH      = 3,
  parameter int unsigned PRESCALE = 1000,
  parameter int unsigned PER_W    = 16,
  parameter int unsigned CH_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [NCH-1:0]   mask_i,
  input  logic             hot_i,
  input  logic [PER_W-1:0] per_norm_i,
  input  logic [PER_W-1:0] per_fast_i,
  input  logic             adc_done_i,
  output logic             adc_start_o,
  output logic [CH_W-1:0]  adc_chan_o,
  output logic             conv_done_o,
  output logic             scan_end_o
);
  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  scan_state_e      st_q;
  logic [CH_W-1:0]  ch_q;
  logic [PRE_W-1:0] pre_q;
  logic [PER_W-1:0] pcnt_q;
  logic             first_v, nxt_v, tick, period_hit;
  logic [CH_W-1:0]  first_c, nxt_c;
  logic [PER_W-1:0] per_sel;

  always_comb begin
    first_v = 1'b0;
    first_c = '0;
    nxt_v   = 1'b0;
    nxt_c   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        first_v = 1'b1;
        first_c = CH_W'(i);
      end
      if (mask_i[i] && (CH_W'(i) > ch_q)) begin
        nxt_v = 1'b1;
        nxt_c = CH_W'(i);
      end
    end
  end

  assign tick        = (pre_q == PRE_W'(PRESCALE - 1));
  assign per_sel     = hot_i ? per_fast_i : per_norm_i;
  // a period of 0 behaves as 1
  assign period_hit  = ((PER_W+1)'(pcnt_q) + (PER_W+1)'(1)) >= (PER_W+1)'(per_sel);
  assign conv_done_o = (st_q == S_WAIT) && adc_done_i;
  assign scan_end_o  = conv_done_o && !(en_i && nxt_v);
  assign adc_start_o = (st_q == S_START);
  assign adc_chan_o  = ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ch_q   <= '0;
      pre_q  <= '0;
      pcnt_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (en_i && first_v) begin
          ch_q <= first_c;
          st_q <= S_START;
        end
        S_START: st_q <= S_WAIT;
        S_WAIT: if (adc_done_i) begin
          if (en_i && nxt_v) begin
            ch_q <= nxt_c;
            st_q <= S_START;
          end else if (en_i) begin
            pre_q  <= '0;
            pcnt_q <= '0;
            st_q   <= S_GAP;
          end else begin
            st_q <= S_IDLE;
          end
        end
        S_GAP: begin
          if (!en_i) begin
            st_q <= S_IDLE;
          end else if (tick) begin
            pre_q <= '0;
            if (period_hit) begin
              ch_q <= first_c;
              st_q <= first_v ? S_START : S_IDLE;
            end else begin
              pcnt_q <= pcnt_q + PER_W'(1);
            end
          end else begin
            pre_q <= pre_q + PRE_W'(1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsc_chan_mon.sv
module tsc_chan_mon #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned DB_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] alarm_cmp_i,
  input  logic [CODE_W-1:0] shut_cmp_i,
  input  logic [DB_W-1:0]   alarm_db_i,
  input  logic [DB_W-1:0]   shut_db_i,
  input  logic              shut_en_i,
  output logic              hot_o,
  output logic              alarm_fire_o,
  output logic              shut_hit_o
);
  logic            alarm_x, shut_x;
  logic [DB_W-1:0] acnt_q, scnt_q;

  function automatic logic reached(logic [DB_W-1:0] cnt, logic [DB_W-1:0] db);
    logic [DB_W:0] need;
    need = (db == '0) ? (DB_W+1)'(1) : (DB_W+1)'(db);
    return ((DB_W+1)'(cnt) + (DB_W+1)'(1)) >= need;
  endfunction

  function automatic logic [DB_W-1:0] bump(logic [DB_W-1:0] cnt);
    return (&cnt) ? cnt : cnt + DB_W'(1);
  endfunction

  // codes fall as temperature rises
  assign alarm_x      = code_i <= alarm_cmp_i;
  assign shut_x       = code_i <= shut_cmp_i;
  assign hot_o        = sample_i && (alarm_x || shut_x);
  assign alarm_fire_o = sample_i && alarm_x && reached(acnt_q, alarm_db_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acnt_q     <= '0;
      scnt_q     <= '0;
      shut_hit_o <= 1'b0;
    end else if (sample_i) begin
      acnt_q <= alarm_x ? bump(acnt_q) : '0;
      scnt_q <= shut_x ? bump(scnt_q) : '0;
      if (shut_en_i && shut_x && reached(scnt_q, shut_db_i)) shut_hit_o <= 1'b1;
    end
  end
endmodule

// File: rtl/tsc_thermal_scan.sv
module tsc_thermal_scan
  import tsc_pkg::*;
#(
  parameter int unsigned NCH          = 3,
  parameter int unsigned CODE_W       = 12,
  parameter int unsigned DB_W         = 8,
  parameter int unsigned PER_W        = 16,
  parameter int unsigned PRESCALE     = 1000,
  parameter int unsigned PER_NORM_RST = 250,
  parameter int unsigned PER_FAST_RST = 50,
  parameter int unsigned DB_RST       = 4,
  localparam int unsigned CH_W        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              adc_start_o,
  output logic [CH_W-1:0]   adc_chan_o,
  input  logic              adc_done_i,
  input  logic [CODE_W-1:0] adc_code_i,
  output logic              irq_o,
  output logic              shut_gpio_o,
  output logic              shut_rst_o
);
  logic              scan_en_q, pol_q, eoc_q, hot_acc_q, hot_q;
  logic [NCH-1:0]    mask_q, aien_q, gpio_rt_q, rst_rt_q, apend_q;
  logic [NCH-1:0]    shut_hit, afire, hot_v, sample;
  logic [CODE_W-1:0] data_q [NCH];
  logic [CODE_W-1:0] acmp_q [NCH];
  logic [CODE_W-1:0] scmp_q [NCH];
  logic [DB_W-1:0]   adb_q, sdb_q;
  logic [PER_W-1:0]  pnorm_q, pfast_q;
  logic              conv_done, scan_end, pend_wr, gpio_act;

  tsc_scan_seq #(.NCH(NCH), .PRESCALE(PRESCALE), .PER_W(PER_W), .CH_W(CH_W)) u_seq (
    .clk_i, .rst_ni,
    .en_i(scan_en_q), .mask_i(mask_q), .hot_i(hot_q),
    .per_norm_i(pnorm_q), .per_fast_i(pfast_q),
    .adc_done_i, .adc_start_o, .adc_chan_o,
    .conv_done_o(conv_done), .scan_end_o(scan_end)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign sample[g] = conv_done && (adc_chan_o == CH_W'(g));
    tsc_chan_mon #(.CODE_W(CODE_W), .DB_W(DB_W)) u_mon (
      .clk_i, .rst_ni,
      .sample_i(sample[g]), .code_i(adc_code_i),
      .alarm_cmp_i(acmp_q[g]), .shut_cmp_i(scmp_q[g]),
      .alarm_db_i(adb_q), .shut_db_i(sdb_q), .shut_en_i(mask_q[g]),
      .hot_o(hot_v[g]), .alarm_fire_o(afire[g]), .shut_hit_o(shut_hit[g])
    );
  end

  assign pend_wr = bus_we_i && (bus_addr_i == OFF_PEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_en_q <= 1'b0;
      pol_q     <= 1'b0;
      mask_q    <= '0;
      aien_q    <= '0;
      gpio_rt_q <= '0;
      rst_rt_q  <= '0;
      apend_q   <= '0;
      eoc_q     <= 1'b0;
      adb_q     <= DB_W'(DB_RST);
      sdb_q     <= DB_W'(DB_RST);
      pnorm_q   <= PER_W'(PER_NORM_RST);
      pfast_q   <= PER_W'(PER_FAST_RST);
      hot_acc_q <= 1'b0;
      hot_q     <= 1'b0;
      for (int n = 0; n < NCH; n++) begin
        data_q[n] <= '0;
        acmp_q[n] <= '0;
        scmp_q[n] <= '0;
      end
    end else begin
      if (bus_we_i) begin
        unique case (bus_addr_i)
          OFF_CTRL: begin
            scan_en_q <= bus_wdata_i[EN_BIT];
            mask_q    <= bus_wdata_i[CH_FIELD +: NCH];
            pol_q     <= bus_wdata_i[POL_BIT];
          end
          OFF_IEN: begin
            aien_q    <= bus_wdata_i[0 +: NCH];
            gpio_rt_q <= bus_wdata_i[GPIO_FLD +: NCH];
            rst_rt_q  <= bus_wdata_i[RST_FLD +: NCH];
          end
          OFF_ADB:   adb_q   <= bus_wdata_i[DB_W-1:0];
          OFF_SDB:   sdb_q   <= bus_wdata_i[DB_W-1:0];
          OFF_PNORM: pnorm_q <= bus_wdata_i[PER_W-1:0];
          OFF_PFAST: pfast_q <= bus_wdata_i[PER_W-1:0];
          default: ;
        endcase
      end
      for (int n = 0; n < NCH; n++) begin
        if (bus_we_i && bus_addr_i == OFF_ACMP + 8'(4 * n)) acmp_q[n] <= bus_wdata_i[CODE_W-1:0];
        if (bus_we_i && bus_addr_i == OFF_SCMP + 8'(4 * n)) scmp_q[n] <= bus_wdata_i[CODE_W-1:0];
        if (sample[n]) data_q[n] <= adc_code_i;
      end
      // a new event wins over a same-cycle clear
      apend_q <= (apend_q & ~(pend_wr ? bus_wdata_i[NCH-1:0] : '0)) | afire;
      eoc_q   <= conv_done | (eoc_q & ~(pend_wr & bus_wdata_i[EOC_BIT]));
      if (scan_end) begin
        hot_q     <= hot_acc_q | (|hot_v);
        hot_acc_q <= 1'b0;
      end else if (conv_done) begin
        hot_acc_q <= hot_acc_q | (|hot_v);
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFF_CTRL: begin
        bus_rdata_o[EN_BIT]             = scan_en_q;
        bus_rdata_o[CH_FIELD +: NCH]    = mask_q;
        bus_rdata_o[POL_BIT]            = pol_q;
      end
      OFF_IEN: begin
        bus_rdata_o[0 +: NCH]           = aien_q;
        bus_rdata_o[GPIO_FLD +: NCH]    = gpio_rt_q;
        bus_rdata_o[RST_FLD +: NCH]     = rst_rt_q;
      end
      OFF_PEND: begin
        bus_rdata_o[0 +: NCH]           = apend_q;
        bus_rdata_o[EOC_BIT]            = eoc_q;
      end
      OFF_ADB:   bus_rdata_o = 32'(adb_q);
      OFF_SDB:   bus_rdata_o = 32'(sdb_q);
      OFF_PNORM: bus_rdata_o = 32'(pnorm_q);
      OFF_PFAST: bus_rdata_o = 32'(pfast_q);
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr_i == OFF_DATA + 8'(4 * n)) bus_rdata_o = 32'(data_q[n]);
      if (bus_addr_i == OFF_ACMP + 8'(4 * n)) bus_rdata_o = 32'(acmp_q[n]);
      if (bus_addr_i == OFF_SCMP + 8'(4 * n)) bus_rdata_o = 32'(scmp_q[n]);
    end
  end

  assign irq_o       = |(apend_q & aien_q);
  assign gpio_act    = |(shut_hit & gpio_rt_q);
  assign shut_gpio_o = pol_q ? gpio_act : ~gpio_act;
  assign shut_rst_o  = |(shut_hit & rst_rt_q);
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int unsigned NCH  = 3,
  parameter int unsigned CH_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            adc_start_i,
  input logic [CH_W-1:0] adc_chan_i,
  input logic            adc_done_i,
  input logic [NCH-1:0]  mask_i,
  input logic [NCH-1:0]  apend_i,
  input logic [NCH-1:0]  shut_hit_i,
  input logic            eoc_i
);
  localparam int unsigned MW = 1 << CH_W;
  logic [MW-1:0] mext;
  assign mext = MW'(mask_i);

  a_r2_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_i |=> !adc_start_i);

  a_r2_start_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_i |-> mext[adc_chan_i]);

  a_r6_alarm_after_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(apend_i & ~$past(apend_i))) |-> $past(adc_done_i));

  a_r8_eoc_after_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_i) |-> $past(adc_done_i));

  a_r9_shut_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(shut_hit_i) & ~shut_hit_i) == '0));

  a_r9_shut_after_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(shut_hit_i & ~$past(shut_hit_i))) |-> $past(adc_done_i));
endmodule

bind tsc_thermal_scan tsc_checker #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .adc_start_i(adc_start_o), .adc_chan_i(adc_chan_o), .adc_done_i(adc_done_i),
  .mask_i(mask_q), .apend_i(apend_q), .shut_hit_i(shut_hit), .eoc_i(eoc_q)
);

// File: tb/tb_tsc_thermal_scan.sv
module tb_tsc_thermal_scan;
  localparam int unsigned NCH = 3;
  localparam int unsigned CH_W = 2;
  localparam int unsigned PRE = 2;
  localparam int unsigned PNORM = 6;
  localparam int unsigned PFAST = 2;
  localparam int GAP_NORM = PNORM * PRE + 1;  // measured from the done drive
  localparam int GAP_FAST = PFAST * PRE + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        adc_start_o, adc_done_i, irq_o, shut_gpio_o, shut_rst_o;
  logic [CH_W-1:0] adc_chan_o;
  logic [11:0] adc_code_i;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, scans_done = 0, last_done_cyc = 0, last_gap = -1, n_starts = 0;
  bit had_done = 0;
  logic [11:0] codes [NCH];
  int exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tsc_thermal_scan #(.NCH(NCH), .PRESCALE(PRE), .PER_NORM_RST(PNORM), .PER_FAST_RST(PFAST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .adc_start_o(adc_start_o), .adc_chan_o(adc_chan_o),
    .adc_done_i(adc_done_i), .adc_code_i(adc_code_i),
    .irq_o(irq_o), .shut_gpio_o(shut_gpio_o), .shut_rst_o(shut_rst_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_scans(int n);
    int target;
    target = scans_done + n;
    wait (scans_done >= target);
    @(negedge clk);
  endtask

  // driver: keeps the expected channel order one scan ahead (channels 0 and 2)
  initial forever begin
    @(posedge clk);
    if (exp_q.size() < 4) begin
      exp_q.push_back(0);
      exp_q.push_back(2);
    end
  end

  // monitor: pops expected channel on every start pulse
  initial forever begin
    @(negedge clk);
    if (adc_start_o) begin
      n_starts++;
      if (exp_q.size() > 0) chk("R2 scan order", 32'(adc_chan_o), 32'(exp_q.pop_front()));
    end
  end

  // converter model: done two cycles after the start pulse
  initial begin
    adc_done_i = 1'b0;
    adc_code_i = '0;
    forever begin
      @(negedge clk);
      adc_done_i = 1'b0;
      if (adc_start_o) begin
        int ch;
        ch = int'(adc_chan_o);
        if (ch == 0 && had_done) last_gap = cyc - last_done_cyc;
        repeat (2) @(negedge clk);
        adc_code_i = codes[ch];
        adc_done_i = 1'b1;
        if (ch == 2) begin
          last_done_cyc = cyc;
          had_done = 1;
          scans_done++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s0;
    for (int i = 0; i < NCH; i++) codes[i] = 12'h800;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(8'h04, v); chk("R1 ctrl reset", v, 32'h0);
    rd(8'h60, v); chk("R1 alarm debounce reset", v, 32'd4);
    rd(8'h64, v); chk("R1 shut debounce reset", v, 32'd4);
    rd(8'h68, v); chk("R1 normal period reset", v, 32'(PNORM));
    rd(8'h6C, v); chk("R1 fast period reset", v, 32'(PFAST));
    rd(8'h0C, v); chk("R1 pending reset", v, 32'h0);
    rd(8'h20, v); chk("R3 data before conversion", v, 32'h0);
    chk("R10 pin idle high at reset", 32'(shut_gpio_o), 32'd1);
    chk("R9 reset request idle", 32'(shut_rst_o), 32'd0);
    chk("R7 irq idle", 32'(irq_o), 32'd0);

    // configure: alarm 0x600, shutdown 0x300, debounce 2 / 3
    wr(8'h30, 32'h600); wr(8'h38, 32'h600);
    wr(8'h40, 32'h300); wr(8'h48, 32'h300);
    rd(8'h38, v); chk("R1 alarm compare ch2", v, 32'h600);
    wr(8'h60, 32'd2); wr(8'h64, 32'd3);
    wr(8'h08, 32'h414);  // alarm en ch2, ch0 -> pin, ch2 -> reset
    wr(8'h04, 32'h051);  // enable, channels 0 and 2, pin active low

    wait_scans(1);
    rd(8'h20, v); chk("R3 data ch0", v, 32'h800);
    rd(8'h28, v); chk("R3 data ch2", v, 32'h800);
    rd(8'h24, v); chk("R3 unscanned ch1 reads 0", v, 32'h0);
    rd(8'h0C, v); chk("R8 end-of-conversion set", v & 32'h100, 32'h100);
    wait_scans(2);
    chk("R4 normal gap", 32'(last_gap), 32'(GAP_NORM));

    // R6 / R5 alarm debounce and fast gap
    codes[2] = 12'h500;
    wait_scans(1);
    rd(8'h0C, v); chk("R6 one sample not enough", v & 32'h4, 32'h0);
    wait_scans(1);
    rd(8'h0C, v); chk("R6 alarm after two samples", v & 32'h4, 32'h4);
    chk("R7 irq with enabled pending", 32'(irq_o), 32'd1);
    chk("R5 fast gap after hot scan", 32'(last_gap), 32'(GAP_FAST));
    codes[2] = 12'h800;
    wait_scans(1);
    wr(8'h0C, 32'h4);
    rd(8'h0C, v); chk("R7 write-1 clears alarm", v & 32'h7, 32'h0);
    chk("R7 irq drops after clear", 32'(irq_o), 32'd0);
    wait_scans(1);
    chk("R5 normal gap after cool scan", 32'(last_gap), 32'(GAP_NORM));

    // R6 broken run does not alarm
    codes[2] = 12'h500; wait_scans(1);
    codes[2] = 12'h800; wait_scans(1);
    codes[2] = 12'h500; wait_scans(1);
    rd(8'h0C, v); chk("R6 cool sample restarts count", v & 32'h4, 32'h0);
    codes[2] = 12'h800; wait_scans(1);

    // R7 alarm on a channel without interrupt enable
    codes[0] = 12'h500;
    wait_scans(2);
    rd(8'h0C, v); chk("R6 alarm ch0", v & 32'h1, 32'h1);
    chk("R7 masked pending gives no irq", 32'(irq_o), 32'd0);
    codes[0] = 12'h800;
    wait_scans(1);
    wr(8'h0C, 32'h1);

    // R9 / R10 shutdown to pin
    codes[0] = 12'h200;
    wait_scans(2);
    chk("R9 shutdown not before debounce", 32'(shut_gpio_o), 32'd1);
    wait_scans(1);
    chk("R10 pin active low", 32'(shut_gpio_o), 32'd0);
    chk("R9 ch0 not routed to reset", 32'(shut_rst_o), 32'd0);
    codes[0] = 12'h800;
    wait_scans(1);
    chk("R9 shutdown sticky after cooling", 32'(shut_gpio_o), 32'd0);
    wr(8'h04, 32'h151);
    chk("R10 pin active high", 32'(shut_gpio_o), 32'd1);

    // R9 shutdown to reset request
    codes[2] = 12'h200;
    wait_scans(3);
    chk("R9 reset request from ch2", 32'(shut_rst_o), 32'd1);
    codes[2] = 12'h800;

    // R11 disable during a conversion
    codes[0] = 12'h123;
    do @(negedge clk); while (!(adc_start_o && adc_chan_o == 0));
    s0 = n_starts;
    wr(8'h04, 32'h150);
    repeat (60) @(negedge clk);
    chk("R11 no start after disable", 32'(n_starts - s0), 32'd0);
    rd(8'h20, v); chk("R11 in-flight code stored", v, 32'h123);
    rd(8'h0C, v); chk("R11 pending kept", v & 32'h4, 32'h4);
    wr(8'h0C, 32'h100);
    rd(8'h0C, v); chk("R8 end-of-conversion cleared", v & 32'h100, 32'h0);
    chk("R7 write 0 keeps alarm bit", v & 32'h4, 32'h4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule